// File: doc/BRIEF.md
# I2C Converter Sample Reader

This block is an I2C bus master that pulls samples from a 12-bit audio analog-to-digital converter. After reset, the first burst request makes it write one setup byte to the converter. That byte selects input channel 0 and the supply-voltage reference. From then on, each burst is a run of read transactions. Each read returns two bytes, which are unpacked into a channel tag and a 12-bit code. The block presents each sample on a valid/ready output. The bus lines are open-drain and are modelled as pull-low enables: a high enable drives the line low, and a low enable releases it to the pull-up.

The controller is a single state machine clocked by a quarter-bit tick, so one SCL period takes four ticks. Its states are:

- **IDLE**: the bus is released. A `start_i` pulse latches the burst length and moves to START.
- **START**: generates the start condition. Moves to SEND with the address byte loaded.
- **SEND**: shifts eight bits out, most significant first. Moves to GETACK.
- **GETACK**: samples the converter's acknowledge. A NACK moves to STOP with the error flag set. After the address byte of the setup write, it moves back to SEND with the setup byte loaded. After the setup byte, it moves to STOP. After a read address, it moves to RECV.
- **RECV**: shifts eight bits in. Moves to PUTACK.
- **PUTACK**: drives ACK after the first data byte and moves back to RECV. Drives NACK after the second data byte and moves to STOP.
- **STOP**: generates the stop condition. On an error it moves to IDLE. After a completed read it moves to HOLD. After the setup write it moves to START.
- **HOLD**: presents the sample. On `smp_ready_i` it moves to START, or to IDLE if this was the last sample of the burst.

Top module: `adc_i2c_reader`

## Requirements
- R1: The setup write happens only on the first burst after reset. It is a start condition, the address byte `{DEV_ADDR, 0}`, the setup byte `CFG_BYTE` (default 8'h10: channel-0 select set, external-reference bit clear), and a stop condition. Later bursts do not repeat it.
- R2: Each read is a start condition, then the address byte `{DEV_ADDR, 1}`, then two data bytes. The master ACKs the first data byte (SDA low) and NACKs the second (SDA released). A stop condition follows, and every start condition has a matching stop.
- R3: The first data byte carries the channel tag in bits 5:4 and code bits 11:8 in bits 3:0. Its bits 7:6 are ignored. The second data byte carries code bits 7:0. `smp_data_o` is the 12-bit code zero-extended to 16 bits, and `smp_chan_o` is the tag.
- R4: A burst delivers exactly `burst_len_i` samples, with the length latched at start. A length of 0 means `DEF_BURST` (default 256).
- R5: While `smp_valid_o` is high and `smp_ready_i` is low, the sample stays stable, both bus lines stay released, and no new transaction begins.
- R6: If the converter NACKs a byte, the block sets `err_o`, issues a stop condition, returns to idle, and delivers no more samples. `err_o` stays high until the next accepted start.
- R7: The SCL period is 4·QDIV clocks, where QDIV = CLK_HZ/(4·SCL_HZ). SCL is high for two of the four quarters.
- R8: When not busy, both bus enables are low. A `start_i` pulse that arrives while busy is ignored.
- R9: After reset, `busy_o`, `err_o`, `smp_valid_o`, `scl_oe_o` and `sda_oe_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launches a burst when idle |
| burst_len_i | input | CNT_W | Samples per burst; 0 selects DEF_BURST |
| scl_oe_o | output | 1 | Pulls SCL low when high |
| sda_oe_o | output | 1 | Pulls SDA low when high |
| sda_i | input | 1 | Resolved SDA line level |
| busy_o | output | 1 | Burst in progress |
| err_o | output | 1 | Converter failed to acknowledge |
| smp_valid_o | output | 1 | Sample available |
| smp_ready_i | input | 1 | Downstream accepts the sample |
| smp_data_o | output | OUT_W | Zero-extended 12-bit code |
| smp_chan_o | output | 2 | Channel tag from the first data byte |

## Verification
The bench pairs the block with a behavioural converter that answers from a vector table. The table includes a first byte whose top two bits are set; a design that failed to mask them would leak nonzero bits into the upper nibble of the data. A long downstream stall tests whether the design keeps the sample stable and the bus parked; a design that got this wrong would start the next read early or lose the sample. A second burst checks that the setup write is not sent again, and a burst length of 0 checks the default count of 256. An address NACK checks that the block aborts the burst; a design that got this wrong would keep clocking reads or produce samples.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SEND,
        ST_GETACK,
        ST_RECV,
        ST_PUTACK,
        ST_STOP,
        ST_HOLD
    } rd_state_t;

    typedef struct packed {
        logic [1:0]  chan;
        logic [11:0] code;
    } adc_word_t;

endpackage

// File: rtl/adc_qtick.sv
module adc_qtick #(
    parameter int QDIV = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || cnt == CW'(QDIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == CW'(QDIV - 1));
endmodule

// File: rtl/adc_word_unpack.sv
module adc_word_unpack
    import adc_rd_pkg::*;
(
    input  logic [5:0] first_b,
    input  logic [7:0] second_b,
    output adc_word_t  word
);
    always_comb begin
        word.chan = first_b[5:4];
        word.code = {first_b[3:0], second_b};
    end
endmodule

// File: rtl/adc_i2c_reader.sv
module adc_i2c_reader
    import adc_rd_pkg::*;
#(
    parameter int           CLK_HZ    = 100_000_000,
    parameter int           SCL_HZ    = 800_000,
    parameter logic [6:0]   DEV_ADDR  = 7'h28,
    parameter logic [7:0]   CFG_BYTE  = 8'h10,
    parameter int           CNT_W     = 16,
    parameter int           DEF_BURST = 256,
    parameter int           OUT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] burst_len_i,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    input  logic             sda_i,
    output logic             busy_o,
    output logic             err_o,
    output logic             smp_valid_o,
    input  logic             smp_ready_i,
    output logic [OUT_W-1:0] smp_data_o,
    output logic [1:0]       smp_chan_o
);
    localparam int QDIV_RAW = CLK_HZ / (4 * SCL_HZ);
    localparam int QDIV     = (QDIV_RAW < 1) ? 1 : QDIV_RAW;

    rd_state_t        state;
    logic [1:0]       q;
    logic [2:0]       bitcnt;
    logic [7:0]       shreg;
    logic             byte_idx;
    logic             cfg_done;
    logic             err_q;
    logic             got_q;
    logic             nack_q;
    logic [CNT_W-1:0] remain;
    logic [5:0]       hi_q;
    logic [7:0]       lo_q;
    logic             tick;
    logic             slot_end;
    logic             mid;
    adc_word_t        word;

    adc_qtick #(.QDIV(QDIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state != ST_IDLE && state != ST_HOLD),
        .tick  (tick)
    );

    adc_word_unpack u_unpack (
        .first_b  (hi_q),
        .second_b (lo_q),
        .word     (word)
    );

    assign slot_end = tick && (q == 2'd3);
    assign mid      = tick && (q == 2'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            q        <= '0;
            bitcnt   <= '0;
            shreg    <= '0;
            byte_idx <= 1'b0;
            cfg_done <= 1'b0;
            err_q    <= 1'b0;
            got_q    <= 1'b0;
            nack_q   <= 1'b0;
            remain   <= '0;
            hi_q     <= '0;
            lo_q     <= '0;
        end else begin
            if (tick) q <= q + 1'b1;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        remain <= (burst_len_i == '0) ? CNT_W'(DEF_BURST) : burst_len_i;
                        err_q  <= 1'b0;
                        state  <= ST_START;
                    end
                end
                ST_START: begin
                    if (slot_end) begin
                        shreg    <= {DEV_ADDR, cfg_done};
                        bitcnt   <= '0;
                        byte_idx <= 1'b0;
                        state    <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (slot_end) begin
                        shreg  <= {shreg[6:0], 1'b0};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == 3'd7) state <= ST_GETACK;
                    end
                end
                ST_GETACK: begin
                    if (mid) nack_q <= sda_i;
                    if (slot_end) begin
                        if (nack_q) begin
                            err_q <= 1'b1;
                            state <= ST_STOP;
                        end else if (!cfg_done && !byte_idx) begin
                            shreg    <= CFG_BYTE;
                            byte_idx <= 1'b1;
                            state    <= ST_SEND;
                        end else if (!cfg_done) begin
                            cfg_done <= 1'b1;
                            state    <= ST_STOP;
                        end else begin
                            bitcnt <= '0;
                            state  <= ST_RECV;
                        end
                    end
                end
                ST_RECV: begin
                    if (mid) shreg <= {shreg[6:0], sda_i};
                    if (slot_end) begin
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == 3'd7) begin
                            if (!byte_idx) hi_q <= shreg[5:0];
                            else           lo_q <= shreg;
                            state <= ST_PUTACK;
                        end
                    end
                end
                ST_PUTACK: begin
                    if (slot_end) begin
                        if (!byte_idx) begin
                            byte_idx <= 1'b1;
                            state    <= ST_RECV;
                        end else begin
                            got_q <= 1'b1;
                            state <= ST_STOP;
                        end
                    end
                end
                ST_STOP: begin
                    if (slot_end) begin
                        if (err_q)      state <= ST_IDLE;
                        else if (got_q) state <= ST_HOLD;
                        else            state <= ST_START;
                    end
                end
                ST_HOLD: begin
                    if (smp_ready_i) begin
                        got_q <= 1'b0;
                        if (remain == CNT_W'(1)) begin
                            state <= ST_IDLE;
                        end else begin
                            remain <= remain - 1'b1;
                            state  <= ST_START;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        scl_oe_o = 1'b0;
        sda_oe_o = 1'b0;
        unique case (state)
            ST_START: begin
                sda_oe_o = (q >= 2'd2);
                scl_oe_o = (q == 2'd3);
            end
            ST_SEND: begin
                scl_oe_o = (q == 2'd0) || (q == 2'd3);
                sda_oe_o = ~shreg[7];
            end
            ST_GETACK, ST_RECV: begin
                scl_oe_o = (q == 2'd0) || (q == 2'd3);
            end
            ST_PUTACK: begin
                scl_oe_o = (q == 2'd0) || (q == 2'd3);
                sda_oe_o = ~byte_idx;
            end
            ST_STOP: begin
                scl_oe_o = (q == 2'd0);
                sda_oe_o = (q <= 2'd1);
            end
            default: begin
                scl_oe_o = 1'b0;
                sda_oe_o = 1'b0;
            end
        endcase
    end

    assign busy_o      = (state != ST_IDLE);
    assign err_o       = err_q;
    assign smp_valid_o = (state == ST_HOLD);
    assign smp_data_o  = {{(OUT_W - 12){1'b0}}, word.code};
    assign smp_chan_o  = word.chan;
endmodule

// File: rtl/adc_i2c_reader_chk.sv
module adc_i2c_reader_chk #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_oe_o,
    input logic             sda_oe_o,
    input logic             busy_o,
    input logic             err_o,
    input logic             smp_valid_o,
    input logic             smp_ready_i,
    input logic [OUT_W-1:0] smp_data_o,
    input logic [1:0]       smp_chan_o
);
    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o && !smp_ready_i |=> smp_valid_o && $stable(smp_data_o) && $stable(smp_chan_o));

    // R5
    bus_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> !scl_oe_o && !sda_oe_o);

    // R8
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !scl_oe_o && !sda_oe_o);

    // R6
    err_no_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !smp_valid_o);

    // R4
    valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> busy_o);

    // R2
    stop_before_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !$past(scl_oe_o) && !$past(sda_oe_o));
endmodule

bind adc_i2c_reader adc_i2c_reader_chk #(.OUT_W(OUT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_oe_o    (scl_oe_o),
    .sda_oe_o    (sda_oe_o),
    .busy_o      (busy_o),
    .err_o       (err_o),
    .smp_valid_o (smp_valid_o),
    .smp_ready_i (smp_ready_i),
    .smp_data_o  (smp_data_o),
    .smp_chan_o  (smp_chan_o)
);

// File: tb/adc_i2c_reader_bench.sv
module adc_i2c_reader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int QD         = 2;

    typedef struct packed {
        logic [7:0]  hi;
        logic [7:0]  lo;
        logic [15:0] data;
        logic [1:0]  chan;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{8'h0A, 8'h5C, 16'h0A5C, 2'd0},
        '{8'h3F, 8'hFF, 16'h0FFF, 2'd3},
        '{8'h10, 8'h00, 16'h0000, 2'd1},
        '{8'h27, 8'h81, 16'h0781, 2'd2},
        '{8'h00, 8'h01, 16'h0001, 2'd0},
        '{8'hC5, 8'hAA, 16'h05AA, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] blen = '0;
    logic        scl_oe, sda_oe, busy, err, valid;
    logic        ready = 1'b0;
    logic [15:0] data;
    logic [1:0]  chan;
    logic        s_pull = 1'b0;
    logic        scl_w, sda_w;

    int n_chk = 0, n_err = 0;
    int n_start = 0, n_stop = 0, n_wr = 0, n_rd = 0, ack_fail = 0, hs_cnt = 0;
    int cyc = 0, last_rise = 0, last_rise_hi = 0, minp = 1000, minhi = 1000;
    logic [7:0] cfg_seen = '0, wr_addr_seen = '0, rd_addr_seen = '0;
    bit s_ack_en = 1'b1;

    assign scl_w = !scl_oe;
    assign sda_w = !(sda_oe || s_pull);

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_i2c_reader #(.CLK_HZ(800_000), .SCL_HZ(100_000)) u_adc_i2c_reader (
        .clk(clk), .rst_n(rst_n), .start_i(start), .burst_len_i(blen),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_w),
        .busy_o(busy), .err_o(err), .smp_valid_o(valid), .smp_ready_i(ready),
        .smp_data_o(data), .smp_chan_o(chan)
    );

    always @(posedge clk) begin
        cyc++;
        if (valid && ready) hs_cnt++;
    end

    always @(posedge scl_w) begin
        if (last_rise > 0 && cyc - last_rise < minp) minp = cyc - last_rise;
        last_rise = cyc;
        last_rise_hi = cyc;
    end
    always @(negedge scl_w) if (last_rise_hi > 0 && cyc - last_rise_hi < minhi) minhi = cyc - last_rise_hi;
    always @(posedge sda_w) if (scl_w && rst_n) n_stop++;

    task automatic recv_byte(output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            @(posedge scl_w);
            b = {b[6:0], sda_w};
        end
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            @(negedge scl_w);
            s_pull = !v[i];
            @(posedge scl_w);
        end
    endtask

    initial begin : converter_model
        logic [7:0] b;
        logic ok;
        forever begin
            @(negedge sda_w);
            if (scl_w && rst_n) begin
                n_start++;
                recv_byte(b);
                ok = s_ack_en && (b[7:1] == 7'h28);
                @(negedge scl_w); s_pull = ok; @(posedge scl_w);
                if (ok && !b[0]) begin
                    wr_addr_seen = b;
                    n_wr++;
                    @(negedge scl_w); s_pull = 1'b0;
                    recv_byte(b);
                    cfg_seen = b;
                    @(negedge scl_w); s_pull = 1'b1; @(posedge scl_w);
                    @(negedge scl_w); s_pull = 1'b0;
                end else if (ok) begin
                    rd_addr_seen = b;
                    send_byte(TBL[n_rd % 6].hi);
                    @(negedge scl_w); s_pull = 1'b0; @(posedge scl_w);
                    if (sda_w) ack_fail++;
                    send_byte(TBL[n_rd % 6].lo);
                    @(negedge scl_w); s_pull = 1'b0; @(posedge scl_w);
                    if (!sda_w) ack_fail++;
                    n_rd++;
                end
            end
        end
    end

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    task automatic pulse_start(input logic [15:0] len);
        @(negedge clk); start = 1'b1; blen = len;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : main
        logic [15:0] snap;
        int hs0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9", "reset outputs", {busy, err, valid, scl_oe, sda_oe}, 5'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Burst 1: table walk with handshake driven per entry
        pulse_start(16'd6);
        for (int i = 0; i < 6; i++) begin
            while (!valid) @(negedge clk);
            if (i == 2) begin
                snap = data;
                repeat (40) @(negedge clk);
                // R5 stalled sample stays, bus parked, no new read
                chk("R5", "valid during stall", valid, 1);
                chk("R5", "data during stall", data, snap);
                chk("R5", "bus during stall", {scl_oe, sda_oe, n_rd[7:0]}, {2'b00, 8'd3});
            end
            // R3 unpack
            chk("R3", "sample data", data, TBL[i].data);
            chk("R3", "sample chan", chan, TBL[i].chan);
            ready = 1'b1;
            @(negedge clk);
            ready = 1'b0;
        end
        wait_idle();
        // R1 setup write
        chk("R1", "setup writes", n_wr, 1);
        chk("R1", "setup byte", cfg_seen, 8'h10);
        chk("R1", "write address", wr_addr_seen, 8'h50);
        // R2 read framing
        chk("R2", "read address", rd_addr_seen, 8'h51);
        chk("R2", "master ack/nack", ack_fail, 0);
        chk("R2", "starts", n_start, 7);
        chk("R2", "stops", n_stop, 7);
        // R4 count
        chk("R4", "burst samples", hs_cnt, 6);
        // R7 SCL timing
        chk("R7", "scl period", minp, 4 * QD);
        chk("R7", "scl high", minhi, 2 * QD);

        // Burst 2: no second setup, start while busy ignored
        ready = 1'b1;
        hs0 = hs_cnt;
        pulse_start(16'd3);
        repeat (50) @(negedge clk);
        pulse_start(16'd5);
        wait_idle();
        chk("R1", "no repeated setup", n_wr, 1);
        chk("R8", "start ignored while busy", hs_cnt - hs0, 3);
        chk("R8", "idle bus released", {scl_oe, sda_oe}, 2'b00);

        // Address NACK
        s_ack_en = 1'b0;
        hs0 = hs_cnt;
        pulse_start(16'd4);
        wait_idle();
        chk("R6", "error flag", err, 1);
        chk("R6", "no samples on nack", hs_cnt - hs0, 0);
        chk("R6", "stop after nack", n_stop, n_start);

        s_ack_en = 1'b1;
        pulse_start(16'd1);
        @(negedge clk);
        chk("R6", "error cleared on start", err, 0);
        wait_idle();
        chk("R6", "recovery sample", hs_cnt - hs0, 1);

        // Default length
        hs0 = hs_cnt;
        pulse_start(16'd0);
        wait_idle();
        chk("R4", "default burst", hs_cnt - hs0, 256);
        chk("R2", "master ack/nack long run", ack_fail, 0);

        finish_run();
    end
endmodule